// File: doc/BRIEF.md
# Asynchronous SRAM byte-lane controller

This block connects a clocked request port to an external asynchronous static memory of 512K words by 32 bits. The memory is built from four 8-bit lanes, and each lane has its own active-low chip enable. A request carries an address, a write flag, 32 bits of write data and a 4-bit lane mask. The controller turns each request into a pin sequence whose phase lengths meet the memory's minimum timing. Each phase length is a whole number of clock cycles, derived from the clock period parameter.

Reads assert output enable together with the chip enables of the masked lanes. The returned word is captured when the access time has elapsed. It is presented with a one-cycle valid pulse, and lanes that were not selected read back as zero. Writes hold output enable high, which allows the shorter write pulse. The controller drives the data bus only while the write enable is low. When a write follows a read, the controller first waits for the memory's output-disable time, so the two sides never drive the bus at once. A write whose mask is all zero completes at once and leaves every pin inactive.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is held, request ready is high, every chip enable, write enable and output enable is high (inactive), the bus driver enable is low and read valid is low.
- R2: A write with a nonzero mask holds write enable low for WR_CYC cycles, where WR_CYC is the largest rounded-up cycle count of write cycle, write pulse, chip-enable-to-end, address-to-end and data setup (2 cycles at an 8 ns clock). During those cycles output enable is high and the bus driver is on with the request data. The request address is on the address pins. Mask bit i pulls chip enable i low and maps to data bits 8i+7:8i.
- R3: A read holds output enable low, write enable high and the bus driver off for RD_CYC cycles, where RD_CYC is the rounded-up maximum of read cycle and access time (2 cycles at 8 ns). Mask bit i pulls chip enable i low.
- R4: The data bus is sampled on the clock edge that ends the last read cycle. Read valid is high for exactly the one following cycle, together with the sampled word. Unselected lanes read as zero.
- R5: Request ready is low from the acceptance edge until the access completes. In the cycle after completion, ready is high and all memory controls are inactive.
- R6: A write whose mask is all zero asserts no chip enable and no write enable, and ready stays high in the following cycle.
- R7: A write that follows a read is preceded by TA_CYC cycles (1 at 8 ns), the rounded-up output-disable time. During these cycles every control is inactive, the bus driver is off and ready is low. A write that follows a write has no such gap.
- R8: The bus driver is never on while output enable is low.
- R9: Each timing limit becomes ceil(limit/clock period) cycles, and any nonzero limit becomes at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Controller idle, request taken |
| req_addr_i | input | ADDR_W | Word address |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | DATA_W | Write data |
| req_mask_i | input | LANES | Lane select, bit i = byte i |
| rd_valid_o | output | 1 | Read data valid pulse |
| rd_data_o | output | DATA_W | Read data |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_ce_n_o | output | LANES | Per-lane chip enables, active low |
| mem_we_n_o | output | 1 | Write enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low |
| mem_dq_o | output | DATA_W | Data to memory |
| mem_dq_oe_o | output | 1 | Data bus driver enable |
| mem_dq_i | input | DATA_W | Data from memory |

## Verification
A wrong phase count shows at the pins within one access: a write or read pulse too short or too long, or ready coming back a cycle early or late. A stuck turnaround flag either drops the gap before a write that follows a read, which the bench sees on the first cycle after acceptance, or adds an unneeded gap between writes. Lane mapping errors show as a wrong chip enable during the access, and as data read back from a lane that was not written or not selected on the valid cycle.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_TURN, ST_WRITE, ST_READ} state_e;

  function automatic int ps_to_cycles(input int t_ps, input int clk_ps);
    if (t_ps <= 0) return 0;
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_cycle_timer.sv
`timescale 1ns/1ps
module sram_cycle_timer #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sram_byte_lane.sv
`timescale 1ns/1ps
module sram_byte_lane #(
  parameter int LANE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_d_i,
  input  logic              cap_i,
  input  logic [LANE_W-1:0] dq_i,
  output logic              ce_n_o,
  output logic [LANE_W-1:0] rd_o
);
  logic              ce_n_q;
  logic [LANE_W-1:0] rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_n_q <= 1'b1;
      rd_q   <= '0;
    end else begin
      ce_n_q <= ~sel_d_i;
      // unselected lane returns zero
      if (cap_i) rd_q <= ce_n_q ? '0 : dq_i;
    end
  end

  assign ce_n_o = ce_n_q;
  assign rd_o   = rd_q;
endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int  CLK_PS    = 8000,
  parameter int  ADDR_W    = 19,
  parameter int  LANES     = 4,
  parameter int  LANE_W    = 8,
  parameter int  T_RC_PS   = 12000,
  parameter int  T_AA_PS   = 12000,
  parameter int  T_WC_PS   = 12000,
  parameter int  T_CW_PS   = 10000,
  parameter int  T_AW_PS   = 10000,
  parameter int  T_WP_PS   = 8000,
  parameter int  T_DW_PS   = 6000,
  parameter int  T_OHZ_PS  = 6000,
  localparam int DATA_W    = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_we_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [LANES-1:0]  req_mask_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LANES-1:0]  mem_ce_n_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int RD_CYC = imax(1, imax(ps_to_cycles(T_RC_PS, CLK_PS),
                                       ps_to_cycles(T_AA_PS, CLK_PS)));
  localparam int WR_CYC = imax(1, imax(imax(ps_to_cycles(T_WC_PS, CLK_PS),
                                            ps_to_cycles(T_CW_PS, CLK_PS)),
                                       imax(imax(ps_to_cycles(T_AW_PS, CLK_PS),
                                                 ps_to_cycles(T_WP_PS, CLK_PS)),
                                            ps_to_cycles(T_DW_PS, CLK_PS))));
  localparam int TA_CYC = imax(1, ps_to_cycles(T_OHZ_PS, CLK_PS));
  localparam int MAX_CYC = imax(RD_CYC, imax(WR_CYC, TA_CYC));
  localparam int CNT_W  = $clog2(MAX_CYC + 1);

  state_e              state_q, state_d;
  logic                accept, null_wr, done, load, cap;
  logic [CNT_W-1:0]    load_val;
  logic                last_rd_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [LANES-1:0]    mask_q, mask_d;
  logic                we_n_q, oe_n_q, dq_oe_q, rd_valid_q;
  logic                drive_d;

  assign accept  = req_valid_i && (state_q == ST_IDLE);
  assign null_wr = req_we_i && (req_mask_i == '0);

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept && !null_wr) begin
          load = 1'b1;
          if (!req_we_i) begin
            state_d  = ST_READ;
            load_val = CNT_W'(RD_CYC - 1);
          end else if (last_rd_q) begin
            state_d  = ST_TURN;
            load_val = CNT_W'(TA_CYC - 1);
          end else begin
            state_d  = ST_WRITE;
            load_val = CNT_W'(WR_CYC - 1);
          end
        end
      end
      ST_TURN: begin
        if (done) begin
          state_d  = ST_WRITE;
          load     = 1'b1;
          load_val = CNT_W'(WR_CYC - 1);
        end
      end
      ST_WRITE: if (done) state_d = ST_IDLE;
      ST_READ:  if (done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  assign mask_d  = accept ? req_mask_i : mask_q;
  assign drive_d = (state_d == ST_WRITE) || (state_d == ST_READ);
  assign cap     = (state_q == ST_READ) && done;

  sram_cycle_timer #(.W(CNT_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .done_o     (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      last_rd_q  <= 1'b0;
      addr_q     <= '0;
      wdata_q    <= '0;
      mask_q     <= '0;
      we_n_q     <= 1'b1;
      oe_n_q     <= 1'b1;
      dq_oe_q    <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      mask_q     <= mask_d;
      if (accept && !null_wr) begin
        last_rd_q <= !req_we_i;
        addr_q    <= req_addr_i;
        wdata_q   <= req_wdata_i;
      end
      // controls registered from next state: glitch-free pins
      we_n_q     <= (state_d != ST_WRITE);
      oe_n_q     <= (state_d != ST_READ);
      dq_oe_q    <= (state_d == ST_WRITE);
      rd_valid_q <= cap;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_byte_lane #(.LANE_W(LANE_W)) i_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_d_i (drive_d && mask_d[g]),
      .cap_i   (cap),
      .dq_i    (mem_dq_i[g*LANE_W +: LANE_W]),
      .ce_n_o  (mem_ce_n_o[g]),
      .rd_o    (rd_data_o[g*LANE_W +: LANE_W])
    );
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rd_valid_o  = rd_valid_q;
  assign mem_addr_o  = addr_q;
  assign mem_we_n_o  = we_n_q;
  assign mem_oe_n_o  = oe_n_q;
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe_o = dq_oe_q;
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
`timescale 1ns/1ps
module sram_lane_ctrl_chk #(
  parameter int ADDR_W = 19,
  parameter int LANES  = 4,
  parameter int DATA_W = 32,
  parameter int WR_CYC = 2,
  parameter int RD_CYC = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              req_we_i,
  input logic [DATA_W-1:0] req_wdata_i,
  input logic [LANES-1:0]  req_mask_i,
  input logic              rd_valid_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [LANES-1:0]  mem_ce_n_o,
  input logic              mem_we_n_o,
  input logic              mem_oe_n_o,
  input logic [DATA_W-1:0] mem_dq_o,
  input logic              mem_dq_oe_o,
  input logic [DATA_W-1:0] mem_dq_i
);
  logic [15:0] we_lo_cnt, oe_lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_lo_cnt <= '0;
      oe_lo_cnt <= '0;
    end else begin
      we_lo_cnt <= mem_we_n_o ? '0 : ((we_lo_cnt == '1) ? we_lo_cnt : we_lo_cnt + 1'b1);
      oe_lo_cnt <= mem_oe_n_o ? '0 : ((oe_lo_cnt == '1) ? oe_lo_cnt : oe_lo_cnt + 1'b1);
    end
  end

  p_wr_oe_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> (mem_oe_n_o && mem_dq_oe_o));
  p_wr_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (we_lo_cnt >= 16'(WR_CYC)));
  p_rd_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_oe_n_o) |-> (oe_lo_cnt >= 16'(RD_CYC)));
  p_rd_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);
  p_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mem_ce_n_o != '1) || !mem_oe_n_o || !mem_we_n_o) |-> !req_ready_o);
  p_wr_has_lane_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> (mem_ce_n_o != '1));
  p_turn_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> $past(mem_oe_n_o));
  p_no_fight_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_n_o);
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .LANES  (LANES),
  .DATA_W (DATA_W),
  .WR_CYC (WR_CYC),
  .RD_CYC (RD_CYC)
) i_chk (.*);

// File: tb/test_sram_lane_ctrl.sv
`timescale 1ns/1ps
module test_sram_lane_ctrl;
  localparam int AW = 19;
  localparam int DW = 32;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  // R9: rounded-up cycle counts at 8 ns
  localparam int EXP_WR = cdiv(12000, 8000);
  localparam int EXP_RD = cdiv(12000, 8000);
  localparam int EXP_TA = cdiv(6000, 8000);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          req_ready_o;
  logic [AW-1:0] req_addr_i = '0;
  logic          req_we_i = 1'b0;
  logic [DW-1:0] req_wdata_i = '0;
  logic [3:0]    req_mask_i = '0;
  logic          rd_valid_o;
  logic [DW-1:0] rd_data_o;
  logic [AW-1:0] mem_addr_o;
  logic [3:0]    mem_ce_n_o;
  logic          mem_we_n_o, mem_oe_n_o, mem_dq_oe_o;
  logic [DW-1:0] mem_dq_o;
  logic [DW-1:0] mem_dq_i;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;
  logic [DW-1:0] mem [16];
  logic [DW-1:0] shadow [16];

  always #4 clk_i = ~clk_i;

  sram_lane_ctrl i_sram_lane_ctrl (.*);

  always_comb begin
    for (int l = 0; l < 4; l++)
      mem_dq_i[l*8 +: 8] = (!mem_oe_n_o && mem_we_n_o && !mem_ce_n_o[l])
                           ? mem[mem_addr_o[3:0]][l*8 +: 8] : 8'hA5;
  end

  always @(posedge clk_i) begin
    if (!mem_we_n_o && mem_dq_oe_o)
      for (int l = 0; l < 4; l++)
        if (!mem_ce_n_o[l]) mem[mem_addr_o[3:0]][l*8 +: 8] <= mem_dq_o[l*8 +: 8];
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] ctl();
    return {req_ready_o, mem_we_n_o, mem_oe_n_o, mem_dq_oe_o, mem_ce_n_o};
  endfunction

  task automatic send(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [3:0] m);
    @(negedge clk_i);
    chk("R5 ready before request", 64'(req_ready_o), 64'd1);
    req_valid_i = 1'b1; req_we_i = we; req_addr_i = a; req_wdata_i = d; req_mask_i = m;
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [3:0] m, input bit turn);
    send(1'b1, a, d, m);
    if (m == 4'h0) begin
      chk("R6 null write pins", 64'(ctl()), 64'({1'b1, 1'b1, 1'b1, 1'b0, 4'hF}));
      return;
    end
    if (turn) begin
      for (int k = 0; k < EXP_TA; k++) begin
        chk("R7 turnaround gap", 64'(ctl()), 64'({1'b0, 1'b1, 1'b1, 1'b0, 4'hF}));
        @(negedge clk_i);
      end
    end
    for (int k = 0; k < EXP_WR; k++) begin
      chk("R2 write pins", 64'(ctl()), 64'({1'b0, 1'b0, 1'b1, 1'b1, ~m}));
      chk("R2 write data", 64'(mem_dq_o), 64'(d));
      chk("R2 write addr", 64'(mem_addr_o), 64'(a));
      @(negedge clk_i);
    end
    chk("R5 idle after write", 64'(ctl()), 64'({1'b1, 1'b1, 1'b1, 1'b0, 4'hF}));
    for (int l = 0; l < 4; l++)
      if (m[l]) shadow[a[3:0]][l*8 +: 8] = d[l*8 +: 8];
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [3:0] m);
    logic [DW-1:0] exp;
    send(1'b0, a, '0, m);
    for (int k = 0; k < EXP_RD; k++) begin
      chk("R3 read pins", 64'(ctl()), 64'({1'b0, 1'b1, 1'b0, 1'b0, ~m}));
      chk("R4 no early valid", 64'(rd_valid_o), 64'd0);
      @(negedge clk_i);
    end
    for (int l = 0; l < 4; l++)
      exp[l*8 +: 8] = m[l] ? shadow[a[3:0]][l*8 +: 8] : 8'h00;
    chk("R4 read valid", 64'(rd_valid_o), 64'd1);
    chk("R4 read data", 64'(rd_data_o), 64'(exp));
    chk("R5 idle after read", 64'(ctl()), 64'({1'b1, 1'b1, 1'b1, 1'b0, 4'hF}));
    @(negedge clk_i);
    chk("R4 valid one cycle", 64'(rd_valid_o), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk_i);
    chk("R1 reset pins", 64'(ctl()), 64'({1'b1, 1'b1, 1'b1, 1'b0, 4'hF}));
    chk("R1 reset valid", 64'(rd_valid_o), 64'd0);
    rst_ni = 1'b1;
    // fill: write after write, no gap
    for (int i = 0; i < 16; i++)
      do_write({15'(i * 613), 4'(i)}, 32'h9E3779B9 * (i + 1), 4'hF, 1'b0);
    // every mask on every word, each read followed by a partial write
    for (int i = 0; i < 16; i++)
      for (int m = 0; m < 16; m++) begin
        do_read({15'(m * 97), 4'(i)}, 4'(m));
        do_write({15'(i * 31), 4'(i)}, (32'h01234567 * (m + 3)) ^ 32'(i), 4'(m), m != 0);
      end
    // null write after read keeps turnaround pending (R6, R7)
    do_read(19'h00005, 4'hF);
    do_write(19'h00005, 32'hDEADBEEF, 4'h0, 1'b0);
    do_write(19'h00005, 32'hCAFEF00D, 4'h6, 1'b1);
    do_read(19'h00005, 4'hF);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule